// File: doc/BRIEF.md
# Periodic Event Rate Divider

This block derives a programmable periodic event from a 32768 Hz time base. The time base arrives as a single-cycle enable, `tick_en`, in the system clock domain. A free-running 16-bit count advances on every tick. A 4-bit rate selector picks a power-of-two period. Each time the count lands on a multiple of that period, the block emits an event.

Every event raises a one-cycle flag-set pulse, which a neighbouring status register uses to latch its periodic flag. When the interrupt enable is high, the event also raises a one-cycle interrupt request. When the square-output enable is high, it raises a one-cycle pulse on the square output. That output is a pulse per event, not a toggling waveform.

Events line up with multiples of the period on the free-running count, not with the moment the rate was programmed. Changing the rate or the enables never restarts the count. The divider is idle when the rate selector is zero or when both enables are low.

Top module: `prd_rate_divider`

## Requirements
- R1: A `rate_sel` value of 0 produces no events: `flag_set`, `irq_req` and `sqw_pulse` all stay low.
- R2: For `rate_sel` values 3 to 15, the period is 2^(`rate_sel` - 1) ticks of `tick_en`. So 3 gives 4 ticks and 15 gives 16384 ticks.
- R3: `rate_sel` values 1 and 2 give the same periods as 8 and 9, which are 128 and 256 ticks.
- R4: The divider runs only when `rate_sel` is nonzero and at least one of `irq_en` and `sqw_en` is 1. Otherwise no output pulses.
- R5: An event occurs on a tick that brings the free-running tick count to a multiple of the period. The count is taken modulo 65536 and is 0 after reset. Changes to `rate_sel`, `irq_en` or `sqw_en` do not reset the count.
- R6: Every event drives `flag_set` high for exactly one clock. That clock follows the clock edge at which the tick was sampled.
- R7: `irq_req` pulses together with `flag_set` only if `irq_en` was 1 at that tick. Otherwise it stays low.
- R8: `sqw_pulse` pulses together with `flag_set`, for one clock, only if `sqw_en` was 1 at that tick.
- R9: While `rst_n` is low, all outputs are low and the tick count is cleared to 0.
- R10: Clocks without `tick_en` neither create events nor advance the tick count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per 32768 Hz tick |
| rate_sel | input | 4 | Rate selector, 0 = off |
| irq_en | input | 1 | Interrupt request enable |
| sqw_en | input | 1 | Square-output pulse enable |
| flag_set | output | 1 | One-cycle pulse per periodic event |
| irq_req | output | 1 | One-cycle interrupt request per qualified event |
| sqw_pulse | output | 1 | One-cycle square-output pulse per qualified event |

## Verification
The assertions assume the tick enable comes from a time base much slower than the system clock. The shortest legal period of four ticks therefore means two events can never fall on adjacent clocks. The stimulus holds to this by spacing ticks only one clock apart at the very least and by never using a rate faster than four ticks. Every rate window in the vector table spans an exact multiple of its period. The expected pulse counts therefore stay independent of the phase the count had when the window began, even across the 16-bit wrap.

// File: rtl/prd_pkg.sv
package prd_pkg;

  localparam int unsigned PRD_CNT_W  = 16;
  localparam int unsigned PRD_CODE_W = 4;
  localparam int unsigned PRD_EXP_W  = $clog2(PRD_CNT_W);

  // decoded rate: whether the divider runs and the period exponent
  typedef struct packed {
    logic                 run;
    logic [PRD_EXP_W-1:0] exp;
  } prd_rate_t;

  // one periodic event and its qualified variants
  typedef struct packed {
    logic flag;
    logic irq;
    logic sqw;
  } prd_evt_t;

endpackage

// File: rtl/prd_rate_decode.sv
module prd_rate_decode
  import prd_pkg::*;
#(
  parameter int unsigned CODE_W = PRD_CODE_W,
  parameter int unsigned EXP_W  = PRD_EXP_W,
  parameter int unsigned REMAP_MAX = 2,
  parameter int unsigned REMAP_ADD = 7
) (
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              irq_en,
  input  logic              sqw_en,
  output prd_rate_t         rate
);

  localparam int unsigned EFF_W = CODE_W + 1;

  logic [EFF_W-1:0] eff_code;
  logic [EFF_W-1:0] exp_full;

  always_comb begin
    // slow remap of the lowest nonzero codes
    if ({1'b0, rate_sel} <= EFF_W'(REMAP_MAX)) begin
      eff_code = {1'b0, rate_sel} + EFF_W'(REMAP_ADD);
    end else begin
      eff_code = {1'b0, rate_sel};
    end
    exp_full = eff_code - EFF_W'(1);
    rate.run = (rate_sel != '0) && (irq_en || sqw_en);
    rate.exp = exp_full[EXP_W-1:0];
  end

endmodule

// File: rtl/prd_tick_counter.sv
module prd_tick_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    if (tick_en) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/prd_boundary_detect.sv
module prd_boundary_detect
  import prd_pkg::*;
#(
  parameter int unsigned CNT_W = PRD_CNT_W,
  parameter int unsigned EXP_W = PRD_EXP_W
) (
  input  logic             tick_en,
  input  prd_rate_t        rate,
  input  logic [CNT_W-1:0] cnt_inc,
  output logic             boundary
);

  logic [CNT_W-1:0] low_mask;

  // one mask bit per count bit: set below the period exponent
  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
    assign low_mask[gi] = (EXP_W'(gi) < rate.exp);
  end

  always_comb begin
    boundary = tick_en && rate.run && ((cnt_inc & low_mask) == '0);
  end

endmodule

// File: rtl/prd_event_out.sv
module prd_event_out
  import prd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     boundary,
  input  logic     irq_en,
  input  logic     sqw_en,
  output prd_evt_t evt_q
);

  prd_evt_t evt_d;

  always_comb begin
    evt_d.flag = boundary;
    evt_d.irq  = boundary && irq_en;
    evt_d.sqw  = boundary && sqw_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt_d;
    end
  end

endmodule

// File: rtl/prd_rate_divider.sv
module prd_rate_divider
  import prd_pkg::*;
#(
  parameter int unsigned CNT_W  = PRD_CNT_W,
  parameter int unsigned CODE_W = PRD_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              irq_en,
  input  logic              sqw_en,
  output logic              flag_set,
  output logic              irq_req,
  output logic              sqw_pulse
);

  localparam int unsigned EXP_W = $clog2(CNT_W);

  prd_rate_t        rate;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             boundary;
  prd_evt_t         evt_q;

  prd_rate_decode #(
    .CODE_W (CODE_W),
    .EXP_W  (EXP_W)
  ) u_decode (
    .rate_sel (rate_sel),
    .irq_en   (irq_en),
    .sqw_en   (sqw_en),
    .rate     (rate)
  );

  prd_tick_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cnt_q   (cnt_q),
    .cnt_inc (cnt_inc)
  );

  prd_boundary_detect #(
    .CNT_W (CNT_W),
    .EXP_W (EXP_W)
  ) u_detect (
    .tick_en  (tick_en),
    .rate     (rate),
    .cnt_inc  (cnt_inc),
    .boundary (boundary)
  );

  prd_event_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .irq_en   (irq_en),
    .sqw_en   (sqw_en),
    .evt_q    (evt_q)
  );

  assign flag_set  = evt_q.flag;
  assign irq_req   = evt_q.irq;
  assign sqw_pulse = evt_q.sqw;

endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [CODE_W-1:0] rate_sel,
  input logic              irq_en,
  input logic              sqw_en,
  input logic              flag_set,
  input logic              irq_req,
  input logic              sqw_pulse
);

  // R1
  off_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> $past(rate_sel) != '0);

  // R4
  needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> $past(irq_en || sqw_en));

  // R6
  single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> !flag_set);

  // R7
  irq_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flag_set && $past(irq_en)));

  // R8
  sqw_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> (flag_set && $past(sqw_en)));

  // R10
  tick_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> $past(tick_en));

endmodule

bind prd_rate_divider prd_checker #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .rate_sel  (rate_sel),
  .irq_en    (irq_en),
  .sqw_en    (sqw_en),
  .flag_set  (flag_set),
  .irq_req   (irq_req),
  .sqw_pulse (sqw_pulse)
);

// File: tb/prd_rate_divider_tb.sv
module prd_rate_divider_tb;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic [3:0] rate_sel;
  logic       irq_en;
  logic       sqw_en;
  logic       flag_set;
  logic       irq_req;
  logic       sqw_pulse;

  int total;
  int bad;
  int n_pf;
  int n_irq;
  int n_sqw;
  bit done;

  typedef struct packed {
    logic [3:0] code;
    logic       pie;
    logic       sqe;
    int         ticks;
    int         gap;
    int         e_pf;
    int         e_irq;
    int         e_sqw;
  } vec_t;

  localparam int NVEC = 10;
  // windows span whole periods, so counts are phase independent
  localparam vec_t VEC [NVEC] = '{
    '{4'd3,  1'b1, 1'b0, 40,    0, 10, 10, 0},  // R2 R7
    '{4'd1,  1'b0, 1'b1, 256,   0, 2,  0,  2},  // R3 R8
    '{4'd2,  1'b1, 1'b1, 512,   1, 2,  2,  2},  // R3
    '{4'd0,  1'b1, 1'b1, 100,   0, 0,  0,  0},  // R1
    '{4'd5,  1'b0, 1'b0, 64,    0, 0,  0,  0},  // R4
    '{4'd8,  1'b1, 1'b0, 256,   0, 2,  2,  0},  // R3
    '{4'd15, 1'b1, 1'b1, 32768, 0, 2,  2,  2},  // R2
    '{4'd6,  1'b0, 1'b1, 96,    2, 3,  0,  3},  // R2 R8
    '{4'd4,  1'b1, 1'b1, 24,    0, 3,  3,  3},  // R2
    '{4'd14, 1'b1, 1'b0, 32768, 0, 4,  4,  0}   // R5 wrap
  };

  prd_rate_divider u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .rate_sel  (rate_sel),
    .irq_en    (irq_en),
    .sqw_en    (sqw_en),
    .flag_set  (flag_set),
    .irq_req   (irq_req),
    .sqw_pulse (sqw_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check3(input string req, input bit p, input bit i, input bit s);
    check({req, " flag_set"}, int'(flag_set), int'(p));
    check({req, " irq_req"}, int'(irq_req), int'(i));
    check({req, " sqw_pulse"}, int'(sqw_pulse), int'(s));
  endtask

  // drive at negedge, let one posedge pass, sample at next negedge
  task automatic step(input bit t);
    tick_en = t;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    n_pf  += int'(flag_set);
    n_irq += int'(irq_req);
    n_sqw += int'(sqw_pulse);
  endtask

  task automatic ticks_quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      step(1'b1);
      check(req, int'(flag_set), 0);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check3("R9 in reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    n_pf = 0; n_irq = 0; n_sqw = 0;
    tick_en = 1'b0; rate_sel = 4'd3; irq_en = 1'b1; sqw_en = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R2 R6: period 4 from count 0
    ticks_quiet(3, "R5 before first boundary");
    step(1'b1);
    check3("R6 event at count 4", 1'b1, 1'b1, 1'b1);
    step(1'b1);
    check3("R6 R8 pulse lasts one clock", 1'b0, 1'b0, 1'b0);
    // R10: idle clocks, count holds at 5
    for (int k = 0; k < 5; k++) begin
      step(1'b0);
      check("R10 no tick", int'(flag_set), 0);
    end
    ticks_quiet(2, "R10 count held");
    // count 7; switch to period 8: next event at count 8
    rate_sel = 4'd4;
    step(1'b1);
    check3("R5 rate change keeps count", 1'b1, 1'b1, 1'b1);
    // R7: interrupt disabled, square still on
    irq_en = 1'b0;
    ticks_quiet(7, "R5 between boundaries");
    step(1'b1);
    check3("R7 irq suppressed", 1'b1, 1'b0, 1'b1);
    // R4: both enables off
    sqw_en = 1'b0;
    ticks_quiet(8, "R4 disabled");
    // re-enable interrupt only; next aligned boundary at 32
    irq_en = 1'b1;
    ticks_quiet(7, "R5 re-enable waits");
    step(1'b1);
    check3("R8 square suppressed", 1'b1, 1'b1, 1'b0);
    // R9: reset mid-run clears the count
    ticks_quiet(2, "R5 partial");
    rate_sel = 4'd3;
    sqw_en = 1'b1;
    do_reset();
    ticks_quiet(3, "R9 count cleared");
    step(1'b1);
    check3("R9 first event after reset", 1'b1, 1'b1, 1'b1);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      rate_sel = VEC[v].code;
      irq_en   = VEC[v].pie;
      sqw_en   = VEC[v].sqe;
      n_pf = 0; n_irq = 0; n_sqw = 0;
      for (int t = 0; t < VEC[v].ticks; t++) begin
        step(1'b1);
        for (int g = 0; g < VEC[v].gap; g++) step(1'b0);
      end
      check($sformatf("R2/R3 vec%0d flag count (R1 R4 R5)", v), n_pf, VEC[v].e_pf);
      check($sformatf("R7 vec%0d irq count", v), n_irq, VEC[v].e_irq);
      check($sformatf("R8 vec%0d sqw count", v), n_sqw, VEC[v].e_sqw);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule